// File: doc/BRIEF.md
# Power-Sequencing Fault Auto-Mask

This block keeps supply-fault interrupts quiet while a monitored rail is ramping. Each of its channels receives four qualified fault flags from the threshold comparators upstream: fast undervoltage, slow undervoltage, fast overvoltage and slow overvoltage. It also receives a flag that says whether the rail is above its off level, and one strobe each for the start of a power-up and the start of a power-down. The block passes the flags on to the interrupt logic, except during a sequencing window, when the three flags that a ramp would trip are held low.

A window opens on a strobe when masking is enabled for that direction. For each direction, a per-channel select bit chooses which event closes the window. A shared 16-bit limit, counted in ticks of a 1 ms strobe, bounds how long a window may stay open. When a rail never reaches its release event within that limit, the mask drops and a sticky timeout fault is raised for that channel. The fault stays until software clears it.

Top module: `seq_automask`

## Requirements
- R1: After reset every channel is idle: each masked flag equals its raw input and every timeout flag is low.
- R2: While a channel's window is open, its fast-UV, slow-UV and fast-OV outputs read 0. Its slow-OV output always equals its raw input.
- R3: A power-up strobe opens a window only if that channel's power-up enable is 1, and a power-down strobe only if its power-down enable is 1. When both strobes are accepted in the same cycle, the power-up window wins. Strobes that arrive while a channel is open or timed out are ignored.
- R4: In a power-up window, release select 0 closes the window once the above-off flag is 1, and select 1 closes it once the raw slow-UV flag is 0. The condition is first evaluated in the cycle after entry, and the outputs are unmasked from the next clock edge onward.
- R5: In a power-down window, release select 0 closes the window once the above-off flag is 0, and select 1 closes it once the raw slow-UV flag is 1. Timing is the same as in R4.
- R6: While a window is open, each 1 ms tick is counted. The clock edge that samples the tick bringing the count to the limit removes the mask and raises that channel's timeout flag. If the release condition holds on that same edge, release wins and no fault is raised.
- R7: A timeout flag stays high until a one-cycle clear pulse for that channel. The clear returns the channel to idle, and the flag reads 0 after that edge.
- R8: A limit of 0 means no masking: strobes open no window. A window that is open when the limit becomes 0 closes on the next edge. No timeout fault results in either case.
- R9: Channels are independent: a window on one channel leaves the outputs of the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| up_req | input | NCH | Power-up start strobe per channel |
| dn_req | input | NCH | Power-down start strobe per channel |
| up_mask_en | input | NCH | Enable masking on power-up |
| dn_mask_en | input | NCH | Enable masking on power-down |
| up_rel_sel | input | NCH | Power-up release event: 0 above-off, 1 slow-UV cleared |
| dn_rel_sel | input | NCH | Power-down release event: 0 below-off, 1 slow-UV set |
| tmo_ms | input | TMO_W | Window limit in ticks, shared by all channels |
| tmo_clr | input | NCH | Clear pulse for the timeout flag |
| above_off | input | NCH | Rail is above its off level |
| uvhf_i | input | NCH | Raw fast undervoltage flag |
| uvlf_i | input | NCH | Raw slow undervoltage flag |
| ovhf_i | input | NCH | Raw fast overvoltage flag |
| ovlf_i | input | NCH | Raw slow overvoltage flag |
| uvhf_o | output | NCH | Masked fast undervoltage flag |
| uvlf_o | output | NCH | Masked slow undervoltage flag |
| ovhf_o | output | NCH | Masked fast overvoltage flag |
| ovlf_o | output | NCH | Slow overvoltage flag, never masked |
| seq_tmo | output | NCH | Sticky sequencing-timeout fault |

## Verification
Only the per-channel state register lies between a strobe, a tick, a release condition or a clear and the outputs. Each of these therefore takes effect on the first rising edge that samples it. Raw flag changes reach the outputs within the same cycle. The bench changes inputs on a falling edge and samples at the next falling edge, after exactly one rising edge. Timeout checks count ticks. The state is checked one tick before the limit and again on the tick that reaches it.

// File: rtl/seqmask_pkg.sv
package seqmask_pkg;
    typedef enum logic [1:0] {
        SM_IDLE = 2'd0,
        SM_UP   = 2'd1,
        SM_DN   = 2'd2,
        SM_TMO  = 2'd3
    } sm_state_e;
endpackage

// File: rtl/seqmask_chan.sv
module seqmask_chan
    import seqmask_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_ms,
    input  logic             up_req,
    input  logic             dn_req,
    input  logic             up_en,
    input  logic             dn_en,
    input  logic             up_sel,
    input  logic             dn_sel,
    input  logic             above_off,
    input  logic             uvlf_raw,
    input  logic             tmo_clr,
    input  logic [TMO_W-1:0] tmo_lim,
    output logic             mask_on,
    output logic             tmo_flag
);
    localparam int CW = TMO_W + 1;

    typedef struct packed {
        sm_state_e        st;
        logic [TMO_W-1:0] cnt;
    } chan_s;

    chan_s cur_q, nxt_d;
    logic  rel_up, rel_dn, rel_now, last_tick, lim_zero;

    always_comb begin
        nxt_d     = cur_q;
        rel_up    = up_sel ? !uvlf_raw : above_off;
        rel_dn    = dn_sel ? uvlf_raw : !above_off;
        rel_now   = (cur_q.st == SM_UP) ? rel_up : rel_dn;
        lim_zero  = (tmo_lim == '0);
        last_tick = tick_ms && (({1'b0, cur_q.cnt} + CW'(1)) >= {1'b0, tmo_lim});
        case (cur_q.st)
            SM_IDLE: begin
                nxt_d.cnt = '0;
                if (!lim_zero) begin
                    if (up_req && up_en)      nxt_d.st = SM_UP;
                    else if (dn_req && dn_en) nxt_d.st = SM_DN;
                end
            end
            SM_UP, SM_DN: begin
                if (rel_now || lim_zero) begin
                    nxt_d.st  = SM_IDLE;
                    nxt_d.cnt = '0;
                end else if (last_tick) begin
                    nxt_d.st  = SM_TMO;
                    nxt_d.cnt = '0;
                end else if (tick_ms) begin
                    nxt_d.cnt = cur_q.cnt + TMO_W'(1);
                end
            end
            default: begin
                nxt_d.cnt = '0;
                if (tmo_clr) nxt_d.st = SM_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st  <= SM_IDLE;
            cur_q.cnt <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mask_on  = (cur_q.st == SM_UP) || (cur_q.st == SM_DN);
    assign tmo_flag = (cur_q.st == SM_TMO);
endmodule

// File: rtl/seqmask_gate.sv
module seqmask_gate #(
    parameter int NCH = 3
) (
    input  logic [NCH-1:0] mask_on,
    input  logic [NCH-1:0] uvhf_i,
    input  logic [NCH-1:0] uvlf_i,
    input  logic [NCH-1:0] ovhf_i,
    input  logic [NCH-1:0] ovlf_i,
    output logic [NCH-1:0] uvhf_o,
    output logic [NCH-1:0] uvlf_o,
    output logic [NCH-1:0] ovhf_o,
    output logic [NCH-1:0] ovlf_o
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign uvhf_o[g] = uvhf_i[g] && !mask_on[g];
        assign uvlf_o[g] = uvlf_i[g] && !mask_on[g];
        assign ovhf_o[g] = ovhf_i[g] && !mask_on[g];
        // slow overvoltage path is never suppressed
        assign ovlf_o[g] = ovlf_i[g];
    end
endmodule

// File: rtl/seq_automask.sv
module seq_automask #(
    parameter int NCH   = 3,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_ms,
    input  logic [NCH-1:0]   up_req,
    input  logic [NCH-1:0]   dn_req,
    input  logic [NCH-1:0]   up_mask_en,
    input  logic [NCH-1:0]   dn_mask_en,
    input  logic [NCH-1:0]   up_rel_sel,
    input  logic [NCH-1:0]   dn_rel_sel,
    input  logic [TMO_W-1:0] tmo_ms,
    input  logic [NCH-1:0]   tmo_clr,
    input  logic [NCH-1:0]   above_off,
    input  logic [NCH-1:0]   uvhf_i,
    input  logic [NCH-1:0]   uvlf_i,
    input  logic [NCH-1:0]   ovhf_i,
    input  logic [NCH-1:0]   ovlf_i,
    output logic [NCH-1:0]   uvhf_o,
    output logic [NCH-1:0]   uvlf_o,
    output logic [NCH-1:0]   ovhf_o,
    output logic [NCH-1:0]   ovlf_o,
    output logic [NCH-1:0]   seq_tmo
);
    logic [NCH-1:0] mask_on;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        seqmask_chan #(.TMO_W(TMO_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_ms   (tick_ms),
            .up_req    (up_req[g]),
            .dn_req    (dn_req[g]),
            .up_en     (up_mask_en[g]),
            .dn_en     (dn_mask_en[g]),
            .up_sel    (up_rel_sel[g]),
            .dn_sel    (dn_rel_sel[g]),
            .above_off (above_off[g]),
            .uvlf_raw  (uvlf_i[g]),
            .tmo_clr   (tmo_clr[g]),
            .tmo_lim   (tmo_ms),
            .mask_on   (mask_on[g]),
            .tmo_flag  (seq_tmo[g])
        );
    end

    seqmask_gate #(.NCH(NCH)) u_gate (
        .mask_on (mask_on),
        .uvhf_i  (uvhf_i),
        .uvlf_i  (uvlf_i),
        .ovhf_i  (ovhf_i),
        .ovlf_i  (ovlf_i),
        .uvhf_o  (uvhf_o),
        .uvlf_o  (uvlf_o),
        .ovhf_o  (ovhf_o),
        .ovlf_o  (ovlf_o)
    );
endmodule

// File: rtl/seq_automask_chk.sv
module seq_automask_chk #(
    parameter int NCH   = 3,
    parameter int TMO_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_ms,
    input logic [NCH-1:0]   up_req,
    input logic [NCH-1:0]   dn_req,
    input logic [NCH-1:0]   up_mask_en,
    input logic [NCH-1:0]   dn_mask_en,
    input logic [NCH-1:0]   up_rel_sel,
    input logic [NCH-1:0]   dn_rel_sel,
    input logic [TMO_W-1:0] tmo_ms,
    input logic [NCH-1:0]   tmo_clr,
    input logic [NCH-1:0]   above_off,
    input logic [NCH-1:0]   uvhf_i,
    input logic [NCH-1:0]   uvlf_i,
    input logic [NCH-1:0]   ovhf_i,
    input logic [NCH-1:0]   ovlf_i,
    input logic [NCH-1:0]   uvhf_o,
    input logic [NCH-1:0]   uvlf_o,
    input logic [NCH-1:0]   ovhf_o,
    input logic [NCH-1:0]   ovlf_o,
    input logic [NCH-1:0]   seq_tmo
);
    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R6
        tmo_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(seq_tmo[g]) |-> $past(tick_ms));

        // R7
        tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            seq_tmo[g] && !tmo_clr[g] |=> seq_tmo[g]);

        // R7
        tmo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tmo_clr[g] |=> !seq_tmo[g]);

        // R8
        zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tmo_ms == '0) && !seq_tmo[g] |=> !seq_tmo[g]);

        // R6
        tmo_unmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
            seq_tmo[g] |-> (uvhf_o[g] == uvhf_i[g]) && (ovhf_o[g] == ovhf_i[g]));

        // R2
        ovlf_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ovlf_i[g]) |-> ovlf_o[g]);
    end
endmodule

bind seq_automask seq_automask_chk #(.NCH(NCH), .TMO_W(TMO_W)) u_chk (.*);

// File: tb/seq_automask_test.sv
module seq_automask_test;
    localparam int NCH   = 3;
    localparam int TMO_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_ms = 1'b0;
    logic [NCH-1:0]   up_req = '0, dn_req = '0;
    logic [NCH-1:0]   up_mask_en = '0, dn_mask_en = '0;
    logic [NCH-1:0]   up_rel_sel = '0, dn_rel_sel = '0;
    logic [TMO_W-1:0] tmo_ms = '0;
    logic [NCH-1:0]   tmo_clr = '0, above_off = '0;
    logic [NCH-1:0]   uvhf_i = '0, uvlf_i = '0, ovhf_i = '0, ovlf_i = '0;
    logic [NCH-1:0]   uvhf_o, uvlf_o, ovhf_o, ovlf_o, seq_tmo;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    seq_automask #(.NCH(NCH), .TMO_W(TMO_W)) uut (.*);

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_up(input int ch);
        up_req[ch] = 1'b1; @(negedge clk); up_req[ch] = 1'b0;
    endtask

    task automatic pulse_dn(input int ch);
        dn_req[ch] = 1'b1; @(negedge clk); dn_req[ch] = 1'b0;
    endtask

    task automatic tick();
        tick_ms = 1'b1; @(negedge clk); tick_ms = 1'b0;
    endtask

    task automatic t_reset();
        uvhf_i = '1; uvlf_i = '1; ovhf_i = '1; ovlf_i = '1;
        @(negedge clk);
        check("R1 uvhf", int'(uvhf_o), 7);
        check("R1 uvlf", int'(uvlf_o), 7);
        check("R1 ovhf", int'(ovhf_o), 7);
        check("R1 tmo", int'(seq_tmo), 0);
    endtask

    task automatic t_up_offthr();
        tmo_ms = 16'd100; up_mask_en[0] = 1'b1; up_rel_sel[0] = 1'b0; above_off[0] = 1'b0;
        pulse_up(0);
        check("R2 uvhf masked", int'(uvhf_o[0]), 0);
        check("R2 uvlf masked", int'(uvlf_o[0]), 0);
        check("R2 ovhf masked", int'(ovhf_o[0]), 0);
        check("R2 ovlf passes", int'(ovlf_o[0]), 1);
        check("R9 other chans", int'(uvhf_o[2:1]), 3);
        cyc(3);
        check("R4 still masked", int'(uvhf_o[0]), 0);
        above_off[0] = 1'b1; @(negedge clk);
        check("R4 release above-off", int'(uvhf_o[0]), 1);
        up_mask_en[0] = 1'b0;
    endtask

    task automatic t_up_uvlf();
        up_mask_en[1] = 1'b1; up_rel_sel[1] = 1'b1; above_off[1] = 1'b1; uvlf_i[1] = 1'b1;
        pulse_up(1);
        cyc(2);
        check("R4 sel1 ignores above-off", int'(uvhf_o[1]), 0);
        uvlf_i[1] = 1'b0; @(negedge clk);
        check("R4 release slow-uv clear", int'(uvhf_o[1]), 1);
        uvlf_i[1] = 1'b1; up_mask_en[1] = 1'b0;
    endtask

    task automatic t_dn();
        dn_mask_en[2] = 1'b1; dn_rel_sel[2] = 1'b0; above_off[2] = 1'b1;
        pulse_dn(2);
        check("R5 dn masked", int'(ovhf_o[2]), 0);
        above_off[2] = 1'b0; @(negedge clk);
        check("R5 release below-off", int'(ovhf_o[2]), 1);
        dn_rel_sel[2] = 1'b1; uvlf_i[2] = 1'b0;
        pulse_dn(2);
        cyc(2);
        check("R5 sel1 ignores below-off", int'(uvhf_o[2]), 0);
        uvlf_i[2] = 1'b1; @(negedge clk);
        check("R5 release slow-uv set", int'(uvhf_o[2]), 1);
        dn_mask_en[2] = 1'b0;
    endtask

    task automatic t_enables();
        up_mask_en[0] = 1'b0; dn_mask_en[0] = 1'b1; above_off[0] = 1'b0;
        pulse_up(0);
        check("R3 up disabled", int'(uvhf_o[0]), 1);
        up_mask_en[0] = 1'b1; up_rel_sel[0] = 1'b0; dn_rel_sel[0] = 1'b0;
        up_req[0] = 1'b1; dn_req[0] = 1'b1; @(negedge clk);
        up_req[0] = 1'b0; dn_req[0] = 1'b0;
        @(negedge clk);
        check("R3 up wins", int'(uvhf_o[0]), 0);
        above_off[0] = 1'b1; @(negedge clk);
        check("R3 up window released", int'(uvhf_o[0]), 1);
        up_mask_en[0] = 1'b0; dn_mask_en[0] = 1'b0;
    endtask

    task automatic t_timeout();
        tmo_ms = 16'd3; up_mask_en[0] = 1'b1; up_rel_sel[0] = 1'b0; above_off[0] = 1'b0;
        pulse_up(0);
        tick(); tick();
        check("R6 before limit masked", int'(uvhf_o[0]), 0);
        check("R6 before limit no fault", int'(seq_tmo[0]), 0);
        tick();
        check("R6 fault at limit", int'(seq_tmo[0]), 1);
        check("R6 unmasked at limit", int'(uvhf_o[0]), 1);
        cyc(4);
        check("R7 sticky", int'(seq_tmo[0]), 1);
        pulse_up(0);
        check("R3 strobe ignored in timeout", int'(uvhf_o[0]), 1);
        tmo_clr[0] = 1'b1; @(negedge clk); tmo_clr[0] = 1'b0;
        check("R7 cleared", int'(seq_tmo[0]), 0);
        tmo_ms = 16'd2;
        pulse_up(0);
        tick();
        tick_ms = 1'b1; above_off[0] = 1'b1; @(negedge clk); tick_ms = 1'b0;
        check("R6 release beats tick", int'(seq_tmo[0]), 0);
        check("R6 released", int'(uvhf_o[0]), 1);
        above_off[0] = 1'b0;
    endtask

    task automatic t_zero();
        tmo_ms = 16'd0; up_mask_en[0] = 1'b1; above_off[0] = 1'b0;
        pulse_up(0);
        check("R8 zero limit no mask", int'(uvhf_o[0]), 1);
        check("R8 zero limit no fault", int'(seq_tmo[0]), 0);
        tmo_ms = 16'd5;
        pulse_up(0);
        check("R8 window open", int'(uvhf_o[0]), 0);
        tmo_ms = 16'd0; @(negedge clk);
        check("R8 limit dropped to zero", int'(uvhf_o[0]), 1);
        check("R8 no fault", int'(seq_tmo[0]), 0);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_up_offthr();
        t_up_uvlf();
        t_dn();
        t_enables();
        t_timeout();
        t_zero();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule